// File: doc/BRIEF.md
# Pin-Selected Audio Serial Receiver

This block takes a three-wire serial stereo stream (bit clock, frame clock and data line) and turns it into parallel samples. A two-bit select input picks the framing: right-justified or I2S, each at two word lengths. The block runs on a fast system clock. It brings the three serial lines into that domain through a small synchronizer and acts on each detected rising edge of the bit clock.

Each completed stereo frame is presented as a left word and a right word. Both are 24 bits wide and left-aligned, with unused low bits cleared. A single-cycle valid strobe marks the update. The select input is static: it is set while reset is held, and the same code would also drive a companion transmit path. Only the receive direction is built here.

Top module: `aud_serial_rx`

## Requirements
- R1: While and after reset, `left_o` and `right_o` read zero and `valid_o` is low until a full frame has been received.
- R2: With `mode_sel` = 2'b00 (right-justified, 24 bits), each output word equals the last 24 data bits sampled before the frame clock toggles. Any leading filler bits of a longer half are ignored.
- R3: With `mode_sel` = 2'b01 (right-justified, 20 bits), output bits [23:4] hold the last 20 data bits before the frame clock toggles, and bits [3:0] are zero.
- R4: With `mode_sel` = 2'b10 (I2S, 16 bits), output bits [23:8] hold the 16 bits sampled starting at the second bit-clock rising edge after a frame-clock toggle, and bits [7:0] are zero. Longer words keep only their first 16 bits.
- R5: With `mode_sel` = 2'b11 (I2S, 24 bits), the output holds the 24 bits starting at the second rising edge after a toggle. A shorter word followed by zero bits comes out left-aligned, and a longer word is cut to its first 24 bits. This works for any half of 24 or more bit clocks, including one whose last word bit falls on the first edge of the next half.
- R6: Frame clock low carries the left channel and high carries the right. Both words are updated together with a one-cycle `valid_o` pulse once the right half has ended, that is, when the frame clock returns low.
- R7: A half already in progress when reset is released is discarded. Every following complete left/right frame yields exactly one valid pulse.
- R8: `left_o` and `right_o` hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Static format select: bit 1 = I2S framing, bit 0 = word length choice |
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk | input | 1 | Frame clock; low = left, high = right |
| sdata | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a frame's words are updated |

## Verification
The bench builds the receiver with its default two-stage synchronizer and drives a bit clock of eight system clocks. It sweeps all four select codes, each under reset, with half-frame lengths from 16 to 32 bit clocks and word lengths from 16 to 32 bits. This reaches the filler-bit, truncation, short-word and exact-fit cases, including the I2S case where the final bit lands on the next half's first edge. Expected words are computed arithmetically from the transmitted values and the selected length.

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdata,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);

  localparam int OUT_W = 24;
  localparam int CNT_W = $clog2(OUT_W + 1);

  logic [SYNC_STAGES-1:0] bclk_sr, lr_sr, sd_sr;
  logic bclk_d, lr_prev, started, left_ok;
  logic [OUT_W-1:0] shift_q, acc_q, left_hold;
  logic [CNT_W-1:0] cnt_q, len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sr <= '0;
      lr_sr   <= '0;
      sd_sr   <= '0;
      bclk_d  <= 1'b0;
    end else begin
      bclk_sr <= {bclk_sr[SYNC_STAGES-2:0], bclk};
      lr_sr   <= {lr_sr[SYNC_STAGES-2:0], lrclk};
      sd_sr   <= {sd_sr[SYNC_STAGES-2:0], sdata};
      bclk_d  <= bclk_sr[SYNC_STAGES-1];
    end
  end

  wire bclk_s = bclk_sr[SYNC_STAGES-1];
  wire lr_s   = lr_sr[SYNC_STAGES-1];
  wire sd_s   = sd_sr[SYNC_STAGES-1];
  wire rise   = bclk_s & ~bclk_d;
  wire toggle = lr_s ^ lr_prev;

  always_comb begin
    case (mode_sel)
      2'b00:   len = CNT_W'(24);
      2'b01:   len = CNT_W'(20);
      2'b10:   len = CNT_W'(16);
      default: len = CNT_W'(24);
    endcase
  end

  wire [OUT_W-1:0] pos_mask = {1'b1, {(OUT_W-1){1'b0}}} >> cnt_q;
  wire             room     = cnt_q < len;
  wire [OUT_W-1:0] bit_in   = (sd_s && room) ? pos_mask : '0;
  wire [OUT_W-1:0] rj_word  = mode_sel[0] ? {shift_q[19:0], 4'b0} : shift_q;
  wire [OUT_W-1:0] i2s_word = acc_q | bit_in;
  wire [OUT_W-1:0] word     = mode_sel[1] ? i2s_word : rj_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev   <= 1'b0;
      started   <= 1'b0;
      left_ok   <= 1'b0;
      shift_q   <= '0;
      acc_q     <= '0;
      cnt_q     <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        lr_prev <= lr_s;
        shift_q <= {shift_q[OUT_W-2:0], sd_s};
        if (toggle) begin
          started <= 1'b1;
          acc_q   <= '0;
          cnt_q   <= '0;
          if (started) begin
            if (!lr_prev) begin
              left_hold <= word;
              left_ok   <= 1'b1;
            end else begin
              left_ok <= 1'b0;
              if (left_ok) begin
                left_o  <= left_hold;
                right_o <= word;
                valid_o <= 1'b1;
              end
            end
          end
        end else if (room) begin
          acc_q <= acc_q | bit_in;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_left_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_o) |-> valid_o);

  p_right_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o);

  p_rj20_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_sel == 2'b01) |-> (left_o[3:0] == 4'h0 && right_o[3:0] == 4'h0));

  p_i2s16_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_sel == 2'b10) |-> (left_o[7:0] == 8'h0 && right_o[7:0] == 8'h0));

endmodule

// File: tb/aud_serial_rx_test.sv
`timescale 1ns/1ps
module aud_serial_rx_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o;

  aud_serial_rx #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bclk(bclk),
    .lrclk(lrclk), .sdata(sdata), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int ns = 0, nr = 0, grp_sent = 0, grp_recv = 0;
  logic [23:0] exp_l [0:31];
  logic [23:0] exp_r [0:31];
  logic carry = 1'b0;
  logic prev_valid = 1'b0;
  logic done = 1'b0;
  string mtag = "R2";

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_n(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [23:0] exp_word(input logic [1:0] m, input logic [31:0] d, input int nb);
    int L;
    logic [31:0] dm, v;
    L = (m == 2'b01) ? 20 : (m == 2'b10) ? 16 : 24;
    dm = d & mask_n(nb);
    if (!m[1]) v = (nb >= L) ? dm : (dm | ~mask_n(nb));
    else       v = (nb >= L) ? (dm >> (nb - L)) : (dm << (L - nb));
    v = (v & mask_n(L)) << (24 - L);
    return v[23:0];
  endfunction

  task automatic send_half(input logic lr, input logic [31:0] d, input int nb, input int H, input logic [1:0] m);
    for (int k = 0; k < H; k++) begin
      logic b;
      if (m[1]) b = (k == 0) ? carry : ((k <= nb) ? d[nb-k] : 1'b0);
      else      b = (k < H - nb) ? 1'b1 : d[H-1-k];
      @(negedge clk);
      bclk = 1'b0; lrclk = lr; sdata = b;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    carry = (m[1] && H <= nb) ? d[nb-H] : 1'b0;
  endtask

  task automatic send_frame(input logic [1:0] m, input logic [31:0] dl, input logic [31:0] dr, input int nb, input int H);
    exp_l[ns] = exp_word(m, dl, nb);
    exp_r[ns] = exp_word(m, dr, nb);
    ns++;
    grp_sent++;
    send_half(1'b0, dl, nb, H, m);
    send_half(1'b1, dr, nb, H, m);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (nr < ns) begin
        check(left_o == exp_l[nr], {mtag, "/R6 left"}, {8'h0, left_o}, {8'h0, exp_l[nr]});
        check(right_o == exp_r[nr], {mtag, "/R6 right"}, {8'h0, right_o}, {8'h0, exp_r[nr]});
      end else begin
        check(1'b0, "R7 unexpected valid", 32'(nr), 32'(ns));
      end
      nr++;
      grp_recv++;
    end
    if (rst_n && valid_o && prev_valid) check(1'b0, "R6 valid longer than one cycle", 32'd2, 32'd1);
    prev_valid = rst_n && valid_o;
  end

  task automatic run_group(input logic [1:0] m);
    int nbs [4];
    int hs  [4];
    logic [23:0] last_l, last_r;
    case (m)
      2'b00: begin nbs = '{24, 24, 24, 24}; hs = '{24, 32, 32, 24}; mtag = "R2"; end
      2'b01: begin nbs = '{20, 24, 20, 32}; hs = '{32, 24, 20, 32}; mtag = "R3"; end
      2'b10: begin nbs = '{16, 24, 16, 32}; hs = '{32, 24, 16, 32}; mtag = "R4"; end
      default: begin nbs = '{24, 16, 20, 32}; hs = '{24, 24, 32, 32}; mtag = "R5"; end
    endcase
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; lrclk = 1'b1; bclk = 1'b0; carry = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    grp_sent = 0; grp_recv = 0;
    send_half(1'b1, 32'h0, 24, 24, m);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] dl, dr;
      dl = 32'h9E37_79B9 * (i + 1 + 4 * m);
      dr = dl ^ 32'h5A3C_96E1 ^ (32'h0101_0101 << i);
      send_frame(m, dl, dr, nbs[i], hs[i]);
    end
    send_half(1'b0, 32'h0, 24, 24, m);
    repeat (20) @(negedge clk);
    check(grp_recv == grp_sent, "R7 valid count per group", 32'(grp_recv), 32'(grp_sent));
    last_l = left_o; last_r = right_o;
    send_half(1'b1, 32'hFFFF_FFFF, 32, 32, m);
    repeat (8) @(negedge clk);
    check(left_o == last_l && right_o == last_r, "R8 outputs held", {8'h0, left_o}, {8'h0, last_l});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(left_o == 24'h0 && right_o == 24'h0, "R1 reset outputs", {8'h0, left_o}, 32'h0);
    check(valid_o == 1'b0, "R1 reset valid", 32'(valid_o), 32'h0);
    rst_n = 1'b1;
    send_half(1'b1, 32'h00AB_CDEF, 24, 24, 2'b00);
    repeat (20) @(negedge clk);
    check(left_o == 24'h0 && right_o == 24'h0 && nr == 0, "R1 R7 no output from partial half",
          {8'h0, right_o}, 32'h0);
    for (int m = 0; m < 4; m++) run_group(2'(m));
    check(nr == ns, "R7 total frames", 32'(nr), 32'(ns));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nr, ns);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule